// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the clock line waveform for the master side of an I2C controller. Four 16-bit period counts set the length of the low and high halves of each SCL period. Each count is given in input clock cycles. One pair of counts serves fast mode and the other serves high-speed mode. A small write/read port loads the counts while the controller is disabled. Raising the enable input starts the waveform with a low phase. Lowering it releases SCL high.

The mode input selects fast or high-speed timing. The preamble input marks the part of a high-speed transfer that is still sent at fast timing: the master code, the START byte or a general call. Both inputs are captured once, at the start of each low phase, so that one SCL period is built from a single pair of counts. Two one-cycle strobes mark the first cycle of every low phase and every high phase. Surrounding logic that shifts data uses these strobes.

Top module: `scl_period_gen`

## Requirements
- R1: After reset the count registers read as follows: fast low (offset 0x20) 100, fast high (offset 0x1C) 60, high-speed low (offset 0x28) 16 and high-speed high (offset 0x24) 8.
- R2: A write to any count register while `enable` is 1 leaves the stored value unchanged.
- R3: A written value below the register's floor is stored as the floor. The floor is 8 for both low counts and 6 for both high counts. A value at or above the floor is stored as written.
- R4: A read returns the stored value whatever the state of `enable`. A read at any other offset returns 0.
- R5: While `enable` is 0, and in the cycle after it is sampled at 0, `scl_out` is 1 and both strobes are 0.
- R6: In the first cycle after `enable` is sampled at 1 from the idle state, `scl_out` goes to 0. Each low phase lasts exactly the selected low count in clock cycles.
- R7: Each high phase lasts exactly the selected high count in cycles. The next low phase follows directly after it.
- R8: When the mode input was 1 at the start of the period, the period uses the high-speed low and high counts. When it was 0, the period uses the fast counts.
- R9: When `hs_mode` and `preamble` are both 1 at the start of a period, the fast low count and the fast high count are used.
- R10: `hs_mode` and `preamble` are sampled only on the edge that starts a low phase. A change at any other time has no effect until the next period.
- R11: `low_strobe` is 1 for exactly the first cycle of each low phase, and `high_strobe` is 1 for exactly the first cycle of each high phase. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the waveform and locks the count registers |
| hs_mode | input | 1 | 1 selects high-speed timing |
| preamble | input | 1 | 1 marks a high-speed preamble sent at fast timing |
| wr_en | input | 1 | Write strobe for the count registers |
| addr | input | AW | Register offset for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| scl_out | output | 1 | SCL drive level: 0 pulls low, 1 releases |
| low_strobe | output | 1 | First cycle of a low phase |
| high_strobe | output | 1 | First cycle of a high phase |

## Verification
The bench builds the block with its default address width of 8, so all four offsets and two unmapped offsets can be reached. It programs small counts between 6 and 12. These small counts let a few hundred cycles cover many complete periods in fast, high-speed and preamble timing, including the clamp floors themselves. At those lengths, toggling the mode every three cycles is bound to land in the middle of a phase, which tests that the mode is only sampled at the start of a low phase.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} scl_phase_e;

  // raise a written count to the register's floor
  function automatic logic [CNT_W-1:0] floor_cnt(input logic [CNT_W-1:0] v,
                                                 input logic [CNT_W-1:0] lim);
    return (v < lim) ? lim : v;
  endfunction

  // pick the count for a phase from the fast/high-speed pair
  function automatic logic [CNT_W-1:0] pick_cnt(input logic use_hs,
                                                input logic [CNT_W-1:0] fast_v,
                                                input logic [CNT_W-1:0] hs_v);
    return use_hs ? hs_v : fast_v;
  endfunction
endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs
  import scl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic [CNT_W-1:0] fs_low,
  output logic [CNT_W-1:0] fs_high,
  output logic [CNT_W-1:0] hs_low,
  output logic [CNT_W-1:0] hs_high
);
  localparam int NREG = 4;
  // index 0 fast low, 1 fast high, 2 high-speed low, 3 high-speed high
  localparam logic [AW-1:0]    OFS  [NREG] = '{AW'(32'h20), AW'(32'h1C), AW'(32'h28), AW'(32'h24)};
  localparam logic [CNT_W-1:0] RSTV [NREG] = '{16'h0064, 16'h003C, 16'h0010, 16'h0008};
  localparam logic [CNT_W-1:0] MINV [NREG] = '{16'd8, 16'd6, 16'd8, 16'd6};

  logic [CNT_W-1:0] cnt_q [NREG];
  logic [NREG-1:0]  hit;
  logic             wr_open;

  assign wr_open = wr_en && !enable;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i] = (addr == OFS[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q[i] <= RSTV[i];
      else if (wr_open && hit[i]) cnt_q[i] <= floor_cnt(wdata, MINV[i]);
    end

    // R2: locked while running
    p_lock_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(cnt_q[i]));
    // R3: stored value never under its floor
    p_floor_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[i] >= MINV[i]);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rdata = cnt_q[i];
  end

  assign fs_low  = cnt_q[0];
  assign fs_high = cnt_q[1];
  assign hs_low  = cnt_q[2];
  assign hs_high = cnt_q[3];

  // R4: offsets are distinct, at most one register answers a read
  p_onehot_r4 : assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hs_mode,
  input  logic             preamble,
  input  logic [CNT_W-1:0] fs_low,
  input  logic [CNT_W-1:0] fs_high,
  input  logic [CNT_W-1:0] hs_low,
  input  logic [CNT_W-1:0] hs_high,
  output logic             scl_out,
  output logic             low_strobe,
  output logic             high_strobe
);
  scl_phase_e       ph;
  logic [CNT_W-1:0] cnt;
  logic             hs_sel;
  logic             lo_stb_q, hi_stb_q;

  // named events for the assertions
  logic             phase_done, start_low, start_high, hs_now;
  logic [CNT_W-1:0] low_len, high_len;

  assign phase_done = (cnt == '0);
  assign start_low  = enable && (ph == PH_IDLE || (ph == PH_HIGH && phase_done));
  assign start_high = enable && (ph == PH_LOW && phase_done);
  assign hs_now     = hs_mode && !preamble;
  assign low_len    = pick_cnt(hs_now, fs_low, hs_low);
  assign high_len   = pick_cnt(hs_sel, fs_high, hs_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      hs_sel   <= 1'b0;
      lo_stb_q <= 1'b0;
      hi_stb_q <= 1'b0;
    end else begin
      lo_stb_q <= start_low;
      hi_stb_q <= start_high;
      if (!enable) begin
        ph  <= PH_IDLE;
        cnt <= '0;
      end else if (start_low) begin
        ph     <= PH_LOW;
        cnt    <= low_len - 1'b1;
        hs_sel <= hs_now;
      end else if (start_high) begin
        ph  <= PH_HIGH;
        cnt <= high_len - 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign scl_out     = (ph != PH_LOW);
  assign low_strobe  = lo_stb_q;
  assign high_strobe = hi_stb_q;

  // R5: released while disabled
  p_idle_rel_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_out && !low_strobe && !high_strobe));
  // R6: a low start pulls the line on the next cycle
  p_low_start_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    start_low |=> !scl_out);
  // R7: a high start releases the line on the next cycle
  p_high_start_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    start_high |=> scl_out);
  // R10: mode selection held between low starts
  p_sel_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !start_low |=> $stable(hs_sel));
  // R11: strobes exclusive and matched to line level
  p_strobe_excl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    !(low_strobe && high_strobe));
  p_lstb_lvl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    low_strobe |-> !scl_out);
  p_hstb_lvl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    high_strobe |-> scl_out);
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hs_mode,
  input  logic             preamble,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             scl_out,
  output logic             low_strobe,
  output logic             high_strobe
);
  logic [CNT_W-1:0] fs_low, fs_high, hs_low, hs_high;

  scl_cnt_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .fs_low  (fs_low),
    .fs_high (fs_high),
    .hs_low  (hs_low),
    .hs_high (hs_high)
  );

  scl_phase_ctr u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .hs_mode     (hs_mode),
    .preamble    (preamble),
    .fs_low      (fs_low),
    .fs_high     (fs_high),
    .hs_low      (hs_low),
    .hs_high     (hs_high),
    .scl_out     (scl_out),
    .low_strobe  (low_strobe),
    .high_strobe (high_strobe)
  );
endmodule

// File: tb/tb_scl_period_gen.sv
module tb_scl_period_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, hs_mode = 1'b0, preamble = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        scl_out, low_strobe, high_strobe;

  int    total = 0, bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // behavioural reference state
  int m_fsl, m_fsh, m_hsl, m_hsh;
  int m_ph = 0, m_left = 0;
  bit m_hs = 1'b0, m_ls = 1'b0, m_hstb = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  scl_period_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hs_mode(hs_mode),
    .preamble(preamble), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .scl_out(scl_out), .low_strobe(low_strobe),
    .high_strobe(high_strobe)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int floor_of(int v, int lim);
    return (v < lim) ? lim : v;
  endfunction

  function automatic int model_read(int a);
    case (a)
      8'h20:   return m_fsl;
      8'h1C:   return m_fsh;
      8'h28:   return m_hsl;
      8'h24:   return m_hsh;
      default: return 0;
    endcase
  endfunction

  // reference model: period counted down from the full length to 1
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fsl = 100; m_fsh = 60; m_hsl = 16; m_hsh = 8;
      m_ph = 0; m_left = 0; m_hs = 0; m_ls = 0; m_hstb = 0;
    end else begin
      m_ls = 0; m_hstb = 0;
      if (!enable) m_ph = 0;
      else if (m_ph == 0 || (m_ph == 2 && m_left == 1)) begin
        m_hs = hs_mode && !preamble;
        m_ph = 1; m_left = m_hs ? m_hsl : m_fsl; m_ls = 1;
      end else if (m_ph == 1 && m_left == 1) begin
        m_ph = 2; m_left = m_hs ? m_hsh : m_fsh; m_hstb = 1;
      end else m_left--;
      if (wr_en && !enable) begin
        case (addr)
          8'h20: m_fsl = floor_of(int'(wdata), 8);
          8'h1C: m_fsh = floor_of(int'(wdata), 6);
          8'h28: m_hsl = floor_of(int'(wdata), 8);
          8'h24: m_hsh = floor_of(int'(wdata), 6);
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(cur_tag, "scl_out", int'(scl_out), (m_ph != 1) ? 1 : 0);
      chk(cur_tag, "low_strobe", int'(low_strobe), int'(m_ls));
      chk(cur_tag, "high_strobe", int'(high_strobe), int'(m_hstb));
      chk(cur_tag, "rdata", int'(rdata), model_read(int'(addr)));
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, int exp);
    @(negedge clk); addr = a;
    @(posedge clk); #2;
    chk(tag, "read", int'(rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset values
    cur_tag = "R1";
    rd_chk("R1", 8'h20, 100);
    rd_chk("R1", 8'h1C, 60);
    rd_chk("R1", 8'h28, 16);
    rd_chk("R1", 8'h24, 8);
    // R4 unmapped offsets
    cur_tag = "R4";
    rd_chk("R4", 8'h00, 0);
    rd_chk("R4", 8'h30, 0);
    // R3 floors
    cur_tag = "R3";
    wr(8'h20, 16'd5);  rd_chk("R3", 8'h20, 8);
    wr(8'h1C, 16'd2);  rd_chk("R3", 8'h1C, 6);
    wr(8'h28, 16'd0);  rd_chk("R3", 8'h28, 8);
    wr(8'h24, 16'd1);  rd_chk("R3", 8'h24, 6);
    wr(8'h28, 16'd9);  rd_chk("R3", 8'h28, 9);
    wr(8'h20, 16'd12); rd_chk("R3", 8'h20, 12);
    wr(8'h1C, 16'd7);  rd_chk("R3", 8'h1C, 7);
    // R6/R7 fast timing
    cur_tag = "R6";
    @(negedge clk); enable = 1'b1;
    @(posedge clk); #2;
    chk("R6", "first low", int'(scl_out), 0);
    chk("R11", "first strobe", int'(low_strobe), 1);
    cur_tag = "R7";
    idle(80);
    // R2 write while running is dropped, R4 read while running
    cur_tag = "R2";
    wr(8'h20, 16'd40);
    rd_chk("R2", 8'h20, 12);
    wr(8'h24, 16'd30);
    rd_chk("R4", 8'h24, 6);
    // R8 high-speed timing
    cur_tag = "R8";
    @(negedge clk); hs_mode = 1'b1;
    idle(80);
    // R9 preamble at fast timing
    cur_tag = "R9";
    @(negedge clk); preamble = 1'b1;
    idle(70);
    @(negedge clk); preamble = 1'b0;
    // R10 mode changes mid-period
    cur_tag = "R10";
    for (int i = 0; i < 30; i++) begin
      idle(3);
      hs_mode = ~hs_mode;
      if (i % 4 == 0) preamble = ~preamble;
    end
    // R11 covered continuously; R5 release on disable
    cur_tag = "R5";
    @(negedge clk); enable = 1'b0;
    @(posedge clk); #2;
    chk("R5", "released", int'(scl_out), 1);
    idle(10);
    finish_run();
  end
endmodule